// File: doc/BRIEF.md
# Add-On Burst Read Data Supplier

This controller sits on the local side of a host bridge and answers the bridge's pass-thru read requests. The bridge pulls its attention line low to signal a pending read. The controller then selects the bridge's pass-thru data register and delivers one 32-bit word per data phase from a local source. In this block the source is an incrementing word counter.

Every phase is written with a write strobe and finished with an active-low ready handshake. Pacing comes from both sides. After each completed phase of a burst, the controller adds its own wait states. While the bridge holds attention high in the middle of a burst, the controller stops and waits. A read is handled as a burst or as a single phase, according to the bridge's burst indicator at the moment a phase completes. The access is over once the bridge releases both attention and the burst indicator.

Top module: `addon_rd_supplier`

## Requirements
- R1: After reset, and while idle, `sel_n`, `wr_n` and `rdy_n` are high, `be_n` is all ones, `addr` is zero and `dout` is 0. The block stays idle until `attn_n` is sampled low.
- R2: When `attn_n` is sampled low while idle, the next cycle has `sel_n` low, `be_n` all zero, `addr` equal to 0x2C, `wr_n` low and `rdy_n` low. The first phase has no wait state.
- R3: A phase completes on a rising edge where `wr_n`, `rdy_n` and `attn_n` are all sampled low. The word on `dout` at that edge is taken, and from the next cycle `dout` carries the following word (previous + 1).
- R4: In a burst, after a completed phase, `rdy_n` is high for exactly `wait_cfg` cycles (0 to 3) and then low again. `wr_n` stays low and `dout` stays unchanged during these cycles.
- R5: While `attn_n` is high and `burst_n` is low during an access, no phase completes. `dout` holds the pending word, and a `rdy_n` that is already low stays low.
- R6: If `burst_n` is high on the edge where a phase completes (single-phase read), `wr_n` and `rdy_n` go high from the next cycle. `sel_n` stays low until the access ends.
- R7: An edge that samples `attn_n` and `burst_n` both high ends the access. From the next cycle the outputs return to the idle values of R1, and an `attn_n` low on that very next edge starts a new access.
- R8: A word that is on `dout` when an access ends without completing it is not consumed. Captured words form the sequence 0, 1, 2, ... with no gap and no repeat across accesses.
- R9: An access that ends during the controller's own wait states also returns to idle, as R7 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| attn_n | input | 1 | Bridge read attention, active low |
| burst_n | input | 1 | Bridge burst indicator, active low |
| wait_cfg | input | WAIT_W | Wait states inserted before each burst phase after the first |
| sel_n | output | 1 | Register select, active low |
| be_n | output | BE_W | Byte enables, active low |
| addr | output | ADDR_W | Register byte offset (0x2C when selected) |
| wr_n | output | 1 | Write strobe, active low |
| rdy_n | output | 1 | Phase ready, active low |
| dout | output | DATA_W | Word supplied to the bridge |

## Verification
A behavioural model is compared against the outputs on every clock. The patterns are:
- Back-to-back bursts with no wait states, which show that phases complete at full rate.
- Bursts where attention drops mid-burst, which separate holding the word from moving on to the next one.
- Wait counts that change from phase to phase, which expose off-by-one errors in the stall length.
- Single-phase reads, which show that the block stops after one word.
- Accesses ended during a wait state and restarted on the very next clock, which test the return to idle and that no word is lost.

A scoreboard follows every captured word and reports any gap or repeat.

// File: rtl/pt_rd_pkg.sv
package pt_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WAIT = 2'd2,
    ST_HOLD = 2'd3
  } seq_st_e;

  localparam int unsigned DEF_REG_OFS = 32'h2C;
endpackage

// File: rtl/pt_wait_timer.sv
module pt_wait_timer #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              tick,
  output logic              last
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - WAIT_W'(1);
    end
  end

  assign last = (cnt_q <= WAIT_W'(1));
endmodule

// File: rtl/pt_word_source.sv
module pt_word_source #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (adv) begin
      word <= word + DATA_W'(1);
    end
  end
endmodule

// File: rtl/pt_seq.sv
module pt_seq
  import pt_rd_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              attn_n,
  input  logic              burst_n,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              tmr_last,
  output logic              sel_n,
  output logic              wr_n,
  output logic              rdy_n,
  output logic              phase_done,
  output logic              tmr_load,
  output logic              tmr_tick
);
  seq_st_e st_q;
  logic    access_end;

  assign access_end = attn_n && burst_n;
  assign phase_done = (st_q == ST_XFER) && !attn_n;
  assign tmr_load   = phase_done && !burst_n && (wait_cfg != '0);
  assign tmr_tick   = (st_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      sel_n <= 1'b1;
      wr_n  <= 1'b1;
      rdy_n <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (!attn_n) begin
            st_q  <= ST_XFER;
            sel_n <= 1'b0;
            wr_n  <= 1'b0;
            rdy_n <= 1'b0;
          end
        end
        ST_XFER: begin
          if (access_end) begin
            st_q  <= ST_IDLE;
            sel_n <= 1'b1;
            wr_n  <= 1'b1;
            rdy_n <= 1'b1;
          end else if (phase_done) begin
            if (burst_n) begin
              st_q  <= ST_HOLD;
              wr_n  <= 1'b1;
              rdy_n <= 1'b1;
            end else if (wait_cfg != '0) begin
              st_q  <= ST_WAIT;
              rdy_n <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (access_end) begin
            st_q  <= ST_IDLE;
            sel_n <= 1'b1;
            wr_n  <= 1'b1;
            rdy_n <= 1'b1;
          end else if (tmr_last) begin
            st_q  <= ST_XFER;
            rdy_n <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (access_end) begin
            st_q  <= ST_IDLE;
            sel_n <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addon_rd_supplier.sv
module addon_rd_supplier
  import pt_rd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int WAIT_W  = 2,
  parameter int REG_OFS = DEF_REG_OFS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              attn_n,
  input  logic              burst_n,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              sel_n,
  output logic [DATA_W/8-1:0] be_n,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_n,
  output logic              rdy_n,
  output logic [DATA_W-1:0] dout
);
  localparam int BE_W = DATA_W / 8;

  logic phase_done;
  logic tmr_load;
  logic tmr_tick;
  logic tmr_last;

  pt_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .attn_n    (attn_n),
    .burst_n   (burst_n),
    .wait_cfg  (wait_cfg),
    .tmr_last  (tmr_last),
    .sel_n     (sel_n),
    .wr_n      (wr_n),
    .rdy_n     (rdy_n),
    .phase_done(phase_done),
    .tmr_load  (tmr_load),
    .tmr_tick  (tmr_tick)
  );

  pt_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(wait_cfg),
    .tick    (tmr_tick),
    .last    (tmr_last)
  );

  pt_word_source #(.DATA_W(DATA_W)) u_src (
    .clk (clk),
    .rst (rst),
    .adv (phase_done),
    .word(dout)
  );

  assign be_n = {BE_W{sel_n}};
  assign addr = sel_n ? '0 : ADDR_W'(REG_OFS);
endmodule

// File: rtl/addon_rd_supplier_chk.sv
module addon_rd_supplier_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int WAIT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              attn_n,
  input logic              burst_n,
  input logic [WAIT_W-1:0] wait_cfg,
  input logic              sel_n,
  input logic [DATA_W/8-1:0] be_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_n,
  input logic              rdy_n,
  input logic [DATA_W-1:0] dout
);
  logic cap;
  assign cap = !wr_n && !rdy_n && !attn_n;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    sel_n |-> (wr_n && rdy_n && (&be_n) && addr == '0));

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n) |-> ($past(!attn_n) && !rdy_n && !wr_n));

  assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
    cap |=> (dout == $past(dout) + DATA_W'(1)));

  assert_nowait_R4: assert property (@(posedge clk) disable iff (rst)
    (cap && !burst_n && wait_cfg == '0) |=> !rdy_n);

  assert_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (cap && !burst_n && wait_cfg != '0) |=> (rdy_n && !wr_n));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && attn_n && !burst_n) |=> $stable(dout));

  assert_single_R6: assert property (@(posedge clk) disable iff (rst)
    (cap && burst_n) |=> (rdy_n && wr_n && !sel_n));

  assert_end_R7: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && attn_n && burst_n) |=> (sel_n && wr_n && rdy_n));
endmodule

bind addon_rd_supplier addon_rd_supplier_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .WAIT_W(WAIT_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .attn_n  (attn_n),
  .burst_n (burst_n),
  .wait_cfg(wait_cfg),
  .sel_n   (sel_n),
  .be_n    (be_n),
  .addr    (addr),
  .wr_n    (wr_n),
  .rdy_n   (rdy_n),
  .dout    (dout)
);

// File: tb/test_addon_rd_supplier.sv
`timescale 1ns/1ps
module test_addon_rd_supplier;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int WAIT_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              attn_n = 1'b1;
  logic              burst_n = 1'b1;
  logic [WAIT_W-1:0] wait_cfg = '0;
  logic              sel_n;
  logic [DATA_W/8-1:0] be_n;
  logic [ADDR_W-1:0] addr;
  logic              wr_n;
  logic              rdy_n;
  logic [DATA_W-1:0] dout;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int m_mode = 0;     // 0 idle, 1 transfer, 2 own wait, 3 single done
  int m_left = 0;
  int m_word = 0;
  int exp_cap = 0;

  always #2 clk = ~clk;

  addon_rd_supplier #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) i_addon_rd_supplier (
    .clk(clk), .rst(rst), .attn_n(attn_n), .burst_n(burst_n), .wait_cfg(wait_cfg),
    .sel_n(sel_n), .be_n(be_n), .addr(addr), .wr_n(wr_n), .rdy_n(rdy_n), .dout(dout)
  );

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_mode = 0; m_word = 0; m_left = 0;
    end else if (m_mode != 0 && attn_n && burst_n) begin
      m_mode = 0;
    end else begin
      case (m_mode)
        0: if (!attn_n) m_mode = 1;
        1: if (!attn_n) begin
             m_word++;
             if (burst_n) m_mode = 3;
             else if (wait_cfg != 0) begin m_mode = 2; m_left = int'(wait_cfg); end
           end
        2: begin m_left--; if (m_left == 0) m_mode = 1; end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit e_sel, e_wr, e_rdy;
    e_sel = (m_mode == 0);
    e_wr  = !(m_mode == 1 || m_mode == 2);
    e_rdy = (m_mode != 1);
    chk(sel_n == e_sel, tag, "sel_n", sel_n, e_sel);
    chk(wr_n == e_wr, tag, "wr_n", wr_n, e_wr);
    chk(rdy_n == e_rdy, tag, "rdy_n", rdy_n, e_rdy);
    chk(be_n == (e_sel ? 4'hF : 4'h0), tag, "be_n", be_n, e_sel ? 15 : 0);
    chk(addr == (e_sel ? 8'h00 : 8'h2C), tag, "addr", addr, e_sel ? 0 : 44);
    chk(dout == DATA_W'(m_word), tag, "dout", dout, m_word);
  endtask

  task automatic step(input bit a, input bit b);
    @(negedge clk);
    compare_all();
    attn_n  = a;
    burst_n = b;
    if (!rst && !wr_n && !rdy_n && !attn_n) begin
      chk(dout == DATA_W'(exp_cap), "R8", "captured word", dout, exp_cap);
      exp_cap++;
    end
  endtask

  initial begin
    wait (cycles > 100000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset and idle
    tag = "R1";
    repeat (3) step(1, 1);
    rst = 1'b0;
    repeat (3) step(1, 1);

    // R2 start, R3 full-rate burst
    tag = "R2"; wait_cfg = 0;
    step(0, 1);
    tag = "R3";
    repeat (5) step(0, 0);
    step(1, 1);
    step(1, 1);

    // R5 bridge stalls mid-burst, with own waits
    tag = "R5"; wait_cfg = 2;
    repeat (4) step(0, 0);
    repeat (2) step(1, 0);
    repeat (4) step(0, 0);
    step(1, 0);
    repeat (3) step(0, 0);
    step(1, 1);
    step(1, 1);

    // R4 wait count varied per cycle
    tag = "R4";
    for (int i = 0; i < 24; i++) begin
      wait_cfg = WAIT_W'((i * 3) % 4);
      step(0, 0);
    end
    step(1, 1);
    step(1, 1);

    // R6 single-phase read
    tag = "R6"; wait_cfg = 1;
    repeat (5) step(0, 1);
    step(1, 1);
    step(1, 1);

    // R9 end during own wait
    tag = "R9"; wait_cfg = 3;
    step(0, 0);
    step(0, 0);
    step(1, 1);
    repeat (2) step(1, 1);

    // R7 end then restart on the very next clock
    tag = "R7"; wait_cfg = 0;
    repeat (2) step(0, 0);
    step(1, 1);
    repeat (3) step(0, 0);
    step(1, 1);
    repeat (2) step(1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule